// File: doc/BRIEF.md
# BCD Timekeeper

This block holds wall-clock time and calendar date in packed BCD. The fields are seconds, minutes, hours, a three-bit day-of-week code, day of month, month and a two-digit year. It advances by one second on each `tick` pulse, which an external prescaler supplies. Hours use either a 24-hour encoding or a 12-hour encoding in which bit 5 flags PM. Month lengths follow the calendar, and February gains a 29th day when the year is divisible by four. An adjust command rounds the time to the nearest minute and asks the prescaler to restart its sub-second count.

Software loads any field through a one-cycle write port and reads fields back through a combinational read port. A `hold` input freezes visible updates while a bus access is in progress. One missed second is replayed when `hold` drops. Registered strobes mark each new minute, hour, day and month, for use by alarm and interrupt logic.

Top module: `bcd_timekeeper`

## Requirements
- R1: Seconds and minutes count 00–59 in BCD. Each tick adds one second. When seconds go from 59 to 00 the minute advances and `min_stb` pulses. When minutes also go from 59 to 00 the hour advances and `hour_stb` pulses. Each strobe is high for the one cycle that follows the update.
- R2: With `mode_24h`=1, hours count 00–23. The step from 23:59:59 gives 00:00:00, advances the date and pulses `day_stb`.
- R3: With `mode_24h`=0, hour bit 5 is PM and bits 4:0 hold BCD 01–12. The hour steps as follows:
  - AM 11 (0x11) goes to noon (0x32).
  - Noon (0x32) goes to 0x21.
  - 0x29 goes to 0x30.
  - PM 11 (0x31) goes to midnight (0x12), advances the date and pulses `day_stb`.
  - Midnight (0x12) goes to 0x01.
- R4: The weekday code runs 0–6 and goes back to 0 after 6. It advances once on each date carry.
- R5: A date carry moves the day to 01 of the next month after the last day of the month. Months 4, 6, 9 and 11 have 30 days. February has 29 days when the BCD year is a multiple of four and 28 days otherwise. Every other month has 31 days.
- R6: Month counts 01–12. Going from 12 to 01 advances the year, which counts 00–99 and goes from 99 to 00. `month_stb` pulses whenever the day goes back to 01.
- R7: `adj_req` with seconds 00–29 clears the seconds and leaves the minute unchanged. With seconds 30–59 it clears the seconds and advances the minute with normal carry and strobes. Either way, `presc_clr` is high for one cycle.
- R8: The field select codes are 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day, 5 month, 6 year and 7 none. A write stores the field's low bits. On readback the unused high bits are 0: bit 7 of seconds and minutes, bits 7:6 of hours and day, bits 7:5 of month and bits 7:3 of the weekday. Code 7 reads 0x00.
- R9: A field loaded with a value that cannot occur is not corrected. The next increment still returns it to a legal value. For example, seconds 0x7F step to 00 with a minute carry, and a 24-hour value of 0x3F steps to 00 with a date carry.
- R10: While `hold` is 1, ticks do not change any field. When `hold` returns to 0, exactly one second is applied at the next clock edge, however many ticks arrived during the hold.
- R11: A write takes priority in its cycle. An `adj_req` in the same cycle is dropped. A tick in the same cycle is applied one cycle later.
- R12: When `adj_req` and a tick fall in the same cycle, only the adjust takes effect. The tick is consumed and any pending second is discarded.
- R13: After a synchronous reset the time is 00:00:00, the weekday is 0, the date is day 01, month 01, year 00, and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-second pulse from the prescaler |
| hold | input | 1 | Freezes visible updates during a bus access |
| adj_req | input | 1 | Round to nearest minute (one-cycle pulse) |
| mode_24h | input | 1 | 1 = 24-hour hours, 0 = 12-hour with PM flag |
| wr_en | input | 1 | Field write strobe |
| wr_sel | input | 3 | Field select for writes |
| wr_data | input | 8 | Write value |
| rd_sel | input | 3 | Field select for reads |
| rd_data | output | 8 | Read value, unused bits zero |
| presc_clr | output | 1 | Restart sub-second count (after adjust) |
| min_stb | output | 1 | New minute began |
| hour_stb | output | 1 | New hour began |
| day_stb | output | 1 | New day began |
| month_stb | output | 1 | New month began |

## Verification
The contested cycle is the one where the once-a-second tick arrives together with a command that also moves the seconds field: an adjust, or a software write. The bench lines up `tick` with `adj_req` on one edge and checks two things: the seconds read 00 right after that edge, and they are still 00 one cycle later. A seconds value of 01 at either point would mean the tick was applied or replayed. For a write, the bench lines up `tick` with a load of 59. It expects 59 after that edge and 00 with a minute strobe one edge later, which shows the tick was deferred and not lost.

// File: rtl/tk_pkg.sv
package tk_pkg;

    localparam int SEC_W  = 7;
    localparam int MIN_W  = 7;
    localparam int HOUR_W = 6;
    localparam int WDAY_W = 3;
    localparam int DAY_W  = 6;
    localparam int MON_W  = 5;
    localparam int YEAR_W = 8;
    localparam int SEL_W  = 3;

    localparam logic [WDAY_W-1:0] WDAY_LAST = 3'd6;

    typedef enum logic [SEL_W-1:0] {
        F_SEC  = 3'd0,
        F_MIN  = 3'd1,
        F_HOUR = 3'd2,
        F_WDAY = 3'd3,
        F_DAY  = 3'd4,
        F_MON  = 3'd5,
        F_YEAR = 3'd6,
        F_NONE = 3'd7
    } field_e;

    typedef struct packed {
        logic [SEC_W-1:0]  sec;
        logic [MIN_W-1:0]  min;
        logic [HOUR_W-1:0] hour;
    } tk_clock_t;

    typedef struct packed {
        logic [WDAY_W-1:0] wday;
        logic [DAY_W-1:0]  day;
        logic [MON_W-1:0]  mon;
        logic [YEAR_W-1:0] year;
    } tk_date_t;

    typedef struct packed {
        logic                carry;
        logic [HOUR_W-1:0]   val;
    } hour_step_t;

    // Two-digit BCD increment; a units digit of 9 or more rolls into tens.
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        logic [3:0] tens;
        logic [3:0] units;
        tens  = v[7:4];
        units = v[3:0];
        if (units >= 4'd9) begin
            tens  = tens + 4'd1;
            units = 4'd0;
        end else begin
            units = units + 4'd1;
        end
        return {tens, units};
    endfunction

    // BCD year divisible by four: (10*t + u) mod 4 == (2*t + u) mod 4.
    function automatic logic is_leap(input logic [7:0] yr);
        logic [1:0] r;
        r = {yr[4], 1'b0} + yr[1:0];
        return (r == 2'd0);
    endfunction

    function automatic logic [7:0] last_day(input logic [7:0] mon, input logic [7:0] yr);
        logic [7:0] d;
        case (mon)
            8'h04, 8'h06, 8'h09, 8'h11: d = 8'h30;
            8'h02:                      d = is_leap(yr) ? 8'h29 : 8'h28;
            default:                    d = 8'h31;
        endcase
        return d;
    endfunction

    // Next hour value in either encoding, with the day carry.
    function automatic hour_step_t hour_next(input logic [HOUR_W-1:0] h, input logic mode24);
        hour_step_t r;
        logic [7:0] h8;
        logic [7:0] lo8;
        logic       pm;
        h8  = {2'b00, h};
        pm  = h[5];
        lo8 = {3'b000, h[4:0]};
        r   = '0;
        if (mode24) begin
            if (h8 >= 8'h23) begin
                r.carry = 1'b1;
                r.val   = '0;
            end else begin
                r.val   = HOUR_W'(bcd_inc(h8));
            end
        end else begin
            if (lo8 == 8'h11) begin
                r.carry = pm;
                r.val   = {~pm, 5'h12};
            end else if (lo8 >= 8'h12) begin
                r.val   = {pm, 5'h01};
            end else begin
                r.val   = {pm, 5'(bcd_inc(lo8))};
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/tk_step_ctrl.sv
module tk_step_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic hold,
    input  logic wr_en,
    input  logic adj_req,
    output logic step,
    output logic adj,
    output logic presc_clr
);

    logic pend_q;
    logic blocked;

    assign blocked = hold | wr_en;
    assign adj     = adj_req & ~wr_en;
    assign step    = ~blocked & ~adj & (tick | pend_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q    <= 1'b0;
            presc_clr <= 1'b0;
        end else begin
            presc_clr <= adj;
            if (adj)
                pend_q <= 1'b0;
            else if (blocked)
                pend_q <= pend_q | tick;
            else
                pend_q <= 1'b0;
        end
    end

endmodule

// File: rtl/tk_clock_regs.sv
module tk_clock_regs
    import tk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic              adj,
    input  logic              mode_24h,
    input  logic              wr_en,
    input  field_e            wr_sel,
    input  logic [7:0]        wr_data,
    output tk_clock_t         q,
    output logic              day_carry,
    output logic              min_stb,
    output logic              hour_stb
);

    logic [7:0] sec8, min8, sec_inc, min_inc8;
    logic       sec_wrap, min_wrap, min_adv, hr_adv;
    hour_step_t hr_n;

    assign sec8     = {1'b0, q.sec};
    assign min8     = {1'b0, q.min};
    assign sec_inc  = bcd_inc(sec8);
    assign min_inc8 = bcd_inc(min8);
    assign sec_wrap = (sec8 >= 8'h59);
    assign min_wrap = (min8 >= 8'h59);
    assign min_adv  = (step & sec_wrap) | (adj & (sec8 >= 8'h30));
    assign hr_adv   = min_adv & min_wrap;
    assign hr_n     = hour_next(q.hour, mode_24h);
    assign day_carry = hr_adv & hr_n.carry;

    always_ff @(posedge clk) begin
        if (rst) begin
            q        <= '0;
            min_stb  <= 1'b0;
            hour_stb <= 1'b0;
        end else begin
            min_stb  <= min_adv;
            hour_stb <= hr_adv;
            if (wr_en) begin
                case (wr_sel)
                    F_SEC:   q.sec  <= wr_data[SEC_W-1:0];
                    F_MIN:   q.min  <= wr_data[MIN_W-1:0];
                    F_HOUR:  q.hour <= wr_data[HOUR_W-1:0];
                    default: ;
                endcase
            end else begin
                if (adj)
                    q.sec <= '0;
                else if (step)
                    q.sec <= sec_wrap ? '0 : sec_inc[SEC_W-1:0];
                if (min_adv)
                    q.min <= min_wrap ? '0 : min_inc8[MIN_W-1:0];
                if (hr_adv)
                    q.hour <= hr_n.val;
            end
        end
    end

endmodule

// File: rtl/tk_date_regs.sv
module tk_date_regs
    import tk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       day_carry,
    input  logic       wr_en,
    input  field_e     wr_sel,
    input  logic [7:0] wr_data,
    output tk_date_t   q,
    output logic       day_stb,
    output logic       month_stb
);

    logic [7:0] day8, mon8, day_inc, mon_inc, year_inc, day_end;
    logic       day_wrap, mon_wrap, year_wrap;

    assign day8      = {2'b00, q.day};
    assign mon8      = {3'b000, q.mon};
    assign day_inc   = bcd_inc(day8);
    assign mon_inc   = bcd_inc(mon8);
    assign year_inc  = bcd_inc(q.year);
    assign day_end   = last_day(mon8, q.year);
    assign day_wrap  = (day8 >= day_end);
    assign mon_wrap  = (mon8 >= 8'h12);
    assign year_wrap = (q.year >= 8'h99);

    always_ff @(posedge clk) begin
        if (rst) begin
            q.wday    <= '0;
            q.day     <= 6'h01;
            q.mon     <= 5'h01;
            q.year    <= '0;
            day_stb   <= 1'b0;
            month_stb <= 1'b0;
        end else begin
            day_stb   <= day_carry;
            month_stb <= day_carry & day_wrap;
            if (wr_en) begin
                case (wr_sel)
                    F_WDAY:  q.wday <= wr_data[WDAY_W-1:0];
                    F_DAY:   q.day  <= wr_data[DAY_W-1:0];
                    F_MON:   q.mon  <= wr_data[MON_W-1:0];
                    F_YEAR:  q.year <= wr_data[YEAR_W-1:0];
                    default: ;
                endcase
            end else if (day_carry) begin
                q.wday <= (q.wday >= WDAY_LAST) ? '0 : WDAY_W'(q.wday + 3'd1);
                if (day_wrap) begin
                    q.day <= 6'h01;
                    q.mon <= mon_wrap ? 5'h01 : mon_inc[MON_W-1:0];
                    if (mon_wrap)
                        q.year <= year_wrap ? '0 : year_inc;
                end else begin
                    q.day <= day_inc[DAY_W-1:0];
                end
            end
        end
    end

endmodule

// File: rtl/bcd_timekeeper.sv
module bcd_timekeeper
    import tk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       hold,
    input  logic       adj_req,
    input  logic       mode_24h,
    input  logic       wr_en,
    input  logic [2:0] wr_sel,
    input  logic [7:0] wr_data,
    input  logic [2:0] rd_sel,
    output logic [7:0] rd_data,
    output logic       presc_clr,
    output logic       min_stb,
    output logic       hour_stb,
    output logic       day_stb,
    output logic       month_stb
);

    logic      step, adj, day_carry;
    tk_clock_t tq;
    tk_date_t  dq;
    field_e    wsel, rsel;

    logic [SEC_W-1:0]  sec_w;
    logic [HOUR_W-1:0] hour_w;
    logic [DAY_W-1:0]  day_w;

    assign wsel   = field_e'(wr_sel);
    assign rsel   = field_e'(rd_sel);
    assign sec_w  = tq.sec;
    assign hour_w = tq.hour;
    assign day_w  = dq.day;

    tk_step_ctrl u_step (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .hold      (hold),
        .wr_en     (wr_en),
        .adj_req   (adj_req),
        .step      (step),
        .adj       (adj),
        .presc_clr (presc_clr)
    );

    tk_clock_regs u_clock (
        .clk       (clk),
        .rst       (rst),
        .step      (step),
        .adj       (adj),
        .mode_24h  (mode_24h),
        .wr_en     (wr_en),
        .wr_sel    (wsel),
        .wr_data   (wr_data),
        .q         (tq),
        .day_carry (day_carry),
        .min_stb   (min_stb),
        .hour_stb  (hour_stb)
    );

    tk_date_regs u_date (
        .clk       (clk),
        .rst       (rst),
        .day_carry (day_carry),
        .wr_en     (wr_en),
        .wr_sel    (wsel),
        .wr_data   (wr_data),
        .q         (dq),
        .day_stb   (day_stb),
        .month_stb (month_stb)
    );

    always_comb begin
        case (rsel)
            F_SEC:   rd_data = 8'(tq.sec);
            F_MIN:   rd_data = 8'(tq.min);
            F_HOUR:  rd_data = 8'(tq.hour);
            F_WDAY:  rd_data = 8'(dq.wday);
            F_DAY:   rd_data = 8'(dq.day);
            F_MON:   rd_data = 8'(dq.mon);
            F_YEAR:  rd_data = dq.year;
            default: rd_data = 8'h00;
        endcase
    end

endmodule

// File: rtl/tk_chk.sv
module tk_chk (
    input logic       clk,
    input logic       rst,
    input logic       hold,
    input logic       wr_en,
    input logic       adj_req,
    input logic       mode_24h,
    input logic [6:0] sec,
    input logic [5:0] hour,
    input logic [5:0] day,
    input logic       presc_clr,
    input logic       min_stb,
    input logic       hour_stb,
    input logic       day_stb,
    input logic       month_stb
);

    // R10
    hold_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (hold && !wr_en && !adj_req) |=> $stable(sec));

    // R1
    minute_sec_zero_chk: assert property (@(posedge clk) disable iff (rst)
        min_stb |-> (sec == 7'h00));

    // R1
    hour_needs_minute_chk: assert property (@(posedge clk) disable iff (rst)
        hour_stb |-> min_stb);

    // R2
    day_needs_hour_chk: assert property (@(posedge clk) disable iff (rst)
        day_stb |-> hour_stb);

    // R3
    day_hour_value_chk: assert property (@(posedge clk) disable iff (rst)
        day_stb |-> (hour == ($past(mode_24h) ? 6'h00 : 6'h12)));

    // R6
    month_day_one_chk: assert property (@(posedge clk) disable iff (rst)
        month_stb |-> (day_stb && day == 6'h01));

    // R7
    adjust_clears_sec_chk: assert property (@(posedge clk) disable iff (rst)
        presc_clr |-> (sec == 7'h00));

    // R11
    write_drops_adjust_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && adj_req) |=> !presc_clr);

endmodule

bind bcd_timekeeper tk_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .hold      (hold),
    .wr_en     (wr_en),
    .adj_req   (adj_req),
    .mode_24h  (mode_24h),
    .sec       (sec_w),
    .hour      (hour_w),
    .day       (day_w),
    .presc_clr (presc_clr),
    .min_stb   (min_stb),
    .hour_stb  (hour_stb),
    .day_stb   (day_stb),
    .month_stb (month_stb)
);

// File: tb/bcd_timekeeper_tb_top.sv
module bcd_timekeeper_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       hold = 1'b0;
    logic       adj_req = 1'b0;
    logic       mode_24h = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic [2:0] rd_sel = 3'd0;
    logic [7:0] rd_data;
    logic       presc_clr, min_stb, hour_stb, day_stb, month_stb;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    bcd_timekeeper dut_i (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .hold      (hold),
        .adj_req   (adj_req),
        .mode_24h  (mode_24h),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .rd_sel    (rd_sel),
        .rd_data   (rd_data),
        .presc_clr (presc_clr),
        .min_stb   (min_stb),
        .hour_stb  (hour_stb),
        .day_stb   (day_stb),
        .month_stb (month_stb)
    );

    // {mode, sec, min, hour, exp sec, exp min, exp hour, exp {min,hour,day,month} strobes}
    localparam logic [52:0] VEC [0:11] = '{
        {1'b1, 8'h00, 8'h00, 8'h00, 8'h01, 8'h00, 8'h00, 4'b0000},
        {1'b1, 8'h09, 8'h00, 8'h00, 8'h10, 8'h00, 8'h00, 4'b0000},
        {1'b1, 8'h59, 8'h00, 8'h00, 8'h00, 8'h01, 8'h00, 4'b1000},
        {1'b1, 8'h59, 8'h59, 8'h09, 8'h00, 8'h00, 8'h10, 4'b1100},
        {1'b1, 8'h59, 8'h59, 8'h23, 8'h00, 8'h00, 8'h00, 4'b1110},
        {1'b0, 8'h59, 8'h59, 8'h11, 8'h00, 8'h00, 8'h32, 4'b1100},
        {1'b0, 8'h59, 8'h59, 8'h32, 8'h00, 8'h00, 8'h21, 4'b1100},
        {1'b0, 8'h59, 8'h59, 8'h31, 8'h00, 8'h00, 8'h12, 4'b1110},
        {1'b0, 8'h59, 8'h59, 8'h12, 8'h00, 8'h00, 8'h01, 4'b1100},
        {1'b0, 8'h59, 8'h59, 8'h29, 8'h00, 8'h00, 8'h30, 4'b1100},
        {1'b1, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h01, 8'h00, 4'b1000},
        {1'b1, 8'h59, 8'h59, 8'h3F, 8'h00, 8'h00, 8'h00, 4'b1110}
    };

    function automatic string vtag(input int i);
        if (i < 4)       return "R1";
        else if (i == 4) return "R2";
        else if (i < 10) return "R3";
        else             return "R9";
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] s, output logic [7:0] v);
        rd_sel = s;
        #1;
        v = rd_data;
    endtask

    task automatic chkf(input string tag, input logic [2:0] s, input logic [7:0] exp);
        logic [7:0] v;
        rd(s, v);
        chk(tag, v, exp);
    endtask

    task automatic wr(input logic [2:0] s, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic set_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
        wr(3'd2, h); wr(3'd1, m); wr(3'd0, s);
    endtask

    task automatic set_date(input logic [7:0] d, input logic [7:0] mo, input logic [7:0] y);
        wr(3'd4, d); wr(3'd5, mo); wr(3'd6, y);
    endtask

    task automatic date_case(input string tag, input logic [7:0] d, input logic [7:0] mo,
                             input logic [7:0] y, input logic [7:0] ed, input logic [7:0] emo,
                             input logic [7:0] ey);
        mode_24h = 1'b1;
        set_date(d, mo, y);
        set_time(8'h23, 8'h59, 8'h59);
        do_tick();
        chkf(tag, 3'd4, ed);
        chkf(tag, 3'd5, emo);
        chkf(tag, 3'd6, ey);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R13 reset state
        chkf("R13 sec",   3'd0, 8'h00);
        chkf("R13 min",   3'd1, 8'h00);
        chkf("R13 hour",  3'd2, 8'h00);
        chkf("R13 wday",  3'd3, 8'h00);
        chkf("R13 day",   3'd4, 8'h01);
        chkf("R13 month", 3'd5, 8'h01);
        chkf("R13 year",  3'd6, 8'h00);
        chk("R13 strobes", {3'b000, presc_clr, min_stb, hour_stb, day_stb, month_stb}, 8'h00);

        // Table walk: R1, R2, R3, R9
        for (int i = 0; i < 12; i++) begin
            mode_24h = VEC[i][52];
            set_time(VEC[i][35:28], VEC[i][43:36], VEC[i][51:44]);
            do_tick();
            chk(vtag(i), {4'h0, min_stb, hour_stb, day_stb, month_stb}, {4'h0, VEC[i][3:0]});
            chkf(vtag(i), 3'd0, VEC[i][27:20]);
            chkf(vtag(i), 3'd1, VEC[i][19:12]);
            chkf(vtag(i), 3'd2, VEC[i][11:4]);
        end

        // R8 readback masks and unused select
        wr(3'd0, 8'hFF); chkf("R8 sec mask",   3'd0, 8'h7F);
        wr(3'd1, 8'hFF); chkf("R8 min mask",   3'd1, 8'h7F);
        wr(3'd2, 8'hFF); chkf("R8 hour mask",  3'd2, 8'h3F);
        wr(3'd3, 8'hFF); chkf("R8 wday mask",  3'd3, 8'h07);
        wr(3'd4, 8'hFF); chkf("R8 day mask",   3'd4, 8'h3F);
        wr(3'd5, 8'hFF); chkf("R8 month mask", 3'd5, 8'h1F);
        wr(3'd6, 8'hFF); chkf("R8 year",       3'd6, 8'hFF);
        wr(3'd7, 8'h55); chkf("R8 none",       3'd7, 8'h00);

        // R4 weekday
        mode_24h = 1'b1;
        set_date(8'h10, 8'h03, 8'h20);
        wr(3'd3, 8'h06);
        set_time(8'h23, 8'h59, 8'h59);
        do_tick();
        chkf("R4 6->0", 3'd3, 8'h00);
        wr(3'd3, 8'h02);
        set_time(8'h23, 8'h59, 8'h59);
        do_tick();
        chkf("R4 2->3", 3'd3, 8'h03);

        // R5 month lengths and leap years
        date_case("R5 jan31", 8'h31, 8'h01, 8'h23, 8'h01, 8'h02, 8'h23);
        date_case("R5 jan30", 8'h30, 8'h01, 8'h23, 8'h31, 8'h01, 8'h23);
        date_case("R5 apr30", 8'h30, 8'h04, 8'h23, 8'h01, 8'h05, 8'h23);
        date_case("R5 feb28 y23", 8'h28, 8'h02, 8'h23, 8'h01, 8'h03, 8'h23);
        date_case("R5 feb28 y24", 8'h28, 8'h02, 8'h24, 8'h29, 8'h02, 8'h24);
        date_case("R5 feb29 y24", 8'h29, 8'h02, 8'h24, 8'h01, 8'h03, 8'h24);
        date_case("R5 feb28 y00", 8'h28, 8'h02, 8'h00, 8'h29, 8'h02, 8'h00);
        date_case("R5 feb28 y10", 8'h28, 8'h02, 8'h10, 8'h01, 8'h03, 8'h10);
        date_case("R5 feb28 y12", 8'h28, 8'h02, 8'h12, 8'h29, 8'h02, 8'h12);

        // R6 month and year wrap
        date_case("R6 dec31 y23", 8'h31, 8'h12, 8'h23, 8'h01, 8'h01, 8'h24);
        chk("R6 month_stb", {7'h0, month_stb}, 8'h01);
        date_case("R6 dec31 y99", 8'h31, 8'h12, 8'h99, 8'h01, 8'h01, 8'h00);

        // R7 adjust below and above the half minute
        set_time(8'h05, 8'h10, 8'h29);
        @(negedge clk); adj_req = 1'b1;
        @(negedge clk); adj_req = 1'b0;
        chkf("R7 low sec", 3'd0, 8'h00);
        chkf("R7 low min", 3'd1, 8'h10);
        chk("R7 low clr", {6'h0, presc_clr, min_stb}, 8'h02);
        set_time(8'h05, 8'h59, 8'h30);
        @(negedge clk); adj_req = 1'b1;
        @(negedge clk); adj_req = 1'b0;
        chkf("R7 high sec",  3'd0, 8'h00);
        chkf("R7 high min",  3'd1, 8'h00);
        chkf("R7 high hour", 3'd2, 8'h06);
        chk("R7 high strobes", {5'h0, presc_clr, min_stb, hour_stb}, 8'h07);

        // R10 hold with several ticks, one replay
        set_time(8'h01, 8'h02, 8'h10);
        @(negedge clk); hold = 1'b1;
        do_tick(); do_tick(); do_tick();
        chkf("R10 held", 3'd0, 8'h10);
        @(negedge clk); hold = 1'b0;
        @(negedge clk);
        chkf("R10 replay", 3'd0, 8'h11);
        @(negedge clk); @(negedge clk);
        chkf("R10 single", 3'd0, 8'h11);

        // R11 write beats adjust; write defers tick
        set_time(8'h01, 8'h20, 8'h45);
        @(negedge clk); wr_en = 1'b1; wr_sel = 3'd0; wr_data = 8'h40; adj_req = 1'b1;
        @(negedge clk); wr_en = 1'b0; adj_req = 1'b0;
        chkf("R11 wr sec", 3'd0, 8'h40);
        chkf("R11 wr min", 3'd1, 8'h20);
        chk("R11 no clr", {7'h0, presc_clr}, 8'h00);
        @(negedge clk); wr_en = 1'b1; wr_sel = 3'd0; wr_data = 8'h59; tick = 1'b1;
        @(negedge clk); wr_en = 1'b0; tick = 1'b0;
        chkf("R11 deferred", 3'd0, 8'h59);
        @(negedge clk);
        chkf("R11 applied sec", 3'd0, 8'h00);
        chkf("R11 applied min", 3'd1, 8'h21);

        // R12 adjust and tick in the same cycle
        set_time(8'h01, 8'h20, 8'h15);
        @(negedge clk); adj_req = 1'b1; tick = 1'b1;
        @(negedge clk); adj_req = 1'b0; tick = 1'b0;
        chkf("R12 sec", 3'd0, 8'h00);
        @(negedge clk);
        chkf("R12 no replay", 3'd0, 8'h00);
        set_time(8'h01, 8'h20, 8'h45);
        @(negedge clk); adj_req = 1'b1; tick = 1'b1;
        @(negedge clk); adj_req = 1'b0; tick = 1'b0;
        @(negedge clk);
        chkf("R12 high sec", 3'd0, 8'h00);
        chkf("R12 high min", 3'd1, 8'h21);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule